// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer with one 32-bit control word. Software reaches it through a simple register port at offset 0x40. The word holds three fields:

- a 7-bit key in bits [15:9];
- a run bit in bit 8;
- a reload count in bits [7:0].

While the stored word has its run bit set, a new write is accepted only if its key is the bitwise inverse of the stored key. Software that services the watchdog must therefore alternate between a key and its complement. A write that arrives while the watchdog is idle is always accepted.

An accepted write does four things: it stores the word, reloads the countdown, starts or stops the countdown, and forgets any earlier expiry. The countdown steps down on a slow tick strobe that comes from outside the block. The first expiry raises a level-held non-maskable interrupt and reloads a short grace count. If the grace count also runs out before software services the watchdog, the block pulses a one-cycle reset request to the system reset controller.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the control word reads 0, `nmi` and `rst_req` are low, and the countdown is stopped, so ticks cause no expiry.
- R2: While the stored bit 8 is 1, a write to 0x40 is ignored unless its bits [15:9] equal the bitwise inverse of the stored bits [15:9]. After an ignored write, the readback is unchanged.
- R3: While the stored bit 8 is 0, every write to 0x40 is accepted, whatever its key.
- R4: An accepted write is stored and read back at `addr` 0x40. Writes to any other address are ignored, and reads there return 0.
- R5: An accepted write reloads the countdown from bits [7:0]. If bit 8 is 1 the countdown runs; if bit 8 is 0 it stops, and ticks then cause no expiry.
- R6: A count field of 0 reloads 256.
- R7: The countdown drops by one on each clock with `tick` high while it is running. It expires on the tick that takes it from 1 to 0, so after a reload of N the N-th tick raises the output on the next clock.
- R8: The first expiry sets `nmi`, which stays high until an accepted write. The countdown reloads GRACE and keeps running.
- R9: Every expiry after the first drives `rst_req` high for exactly one clock, and the countdown reloads GRACE again.
- R10: An accepted write clears `nmi` and the expiry history, so the next expiry counts as a first expiry again.
- R11: When an accepted write and a tick fall in the same clock, the write takes effect and that tick is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow countdown strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address (control at 0x40) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| nmi | output | 1 | Non-maskable interrupt, level |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Directed sequences cover the corner cases:

- the first write after reset, made with an arbitrary key;
- a wrong key while enabled, which separates the key check from a plain store;
- a zero count, which separates 256 from 0;
- a stop command followed by many ticks;
- a write that coincides with a tick;
- a write to a foreign address.

After that, random traffic mixes:

- sparse ticks;
- writes with correct keys, random keys and foreign addresses;
- small and large counts.

The random traffic drives both stages of expiry many times. Against a cycle-level expectation, it tells apart off-by-one countdowns, a missing history clear and a stretched reset pulse.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h40,
  parameter int GRACE = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              nmi,
  output logic              rst_req
);
  localparam int CNT_W = 9;
  localparam logic [CNT_W-1:0] GRACE_V = CNT_W'(GRACE);

  logic [31:0]      ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, hit_q;

  logic [6:0] key_inv;
  logic       sel, accept, expire;
  logic [CNT_W-1:0] reload;

  assign sel     = addr == CTRL_ADDR;
  assign key_inv = ~ctrl_q[15:9];
  assign accept  = wr_en && sel && (!ctrl_q[8] || wdata[15:9] == key_inv);
  assign expire  = run_q && tick && cnt_q == CNT_W'(1);
  assign reload  = (wdata[7:0] == 8'd0) ? CNT_W'(256) : {1'b0, wdata[7:0]};
  assign rdata   = sel ? ctrl_q : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      hit_q   <= 1'b0;
      nmi     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (accept) begin
        ctrl_q <= wdata;
        cnt_q  <= reload;
        run_q  <= wdata[8];
        hit_q  <= 1'b0;
        nmi    <= 1'b0;
      end else if (expire) begin
        cnt_q <= GRACE_V;
        if (hit_q) rst_req <= 1'b1;
        else begin
          hit_q <= 1'b1;
          nmi   <= 1'b1;
        end
      end else if (run_q && tick) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

module keyed_watchdog_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       ctrl_q,
  input logic              nmi,
  input logic              rst_req
);
  logic bad_key;
  assign bad_key = wr_en && addr == CTRL_ADDR && ctrl_q[8] &&
                   (wdata[15:9] != ~ctrl_q[15:9]);

  // R9
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R9
  rst_after_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> nmi);
  // R8
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi && !wr_en |=> nmi);
  // R2
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_key |=> ctrl_q == $past(ctrl_q));
  // R10
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == CTRL_ADDR && !ctrl_q[8] |=> !nmi);
  // R7
  nmi_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi) |-> $past(tick));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .ctrl_q(ctrl_q), .nmi(nmi), .rst_req(rst_req));

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
  localparam int GRACE = 10;
  localparam logic [7:0] CA = 8'h40;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic nmi, rst_req;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_ctrl;
  int m_cnt;
  bit m_run, m_hit, m_nmi, m_rst;

  always #2.5 clk = ~clk;

  keyed_watchdog #(.GRACE(GRACE)) u_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .nmi(nmi), .rst_req(rst_req));

  function automatic logic [31:0] mk(logic [6:0] key, bit run, logic [7:0] cnt);
    return {16'd0, key, run, cnt};
  endfunction

  function automatic logic [6:0] good_key();
    return ~m_ctrl[15:9];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_edge(bit w, logic [7:0] a, logic [31:0] d, bit t);
    logic [6:0] ki;
    ki = ~m_ctrl[15:9];
    m_rst = 0;
    if (w && a == CA && (!m_ctrl[8] || d[15:9] == ki)) begin
      m_ctrl = d;
      m_cnt  = (d[7:0] == 0) ? 256 : int'(d[7:0]);
      m_run  = d[8];
      m_hit  = 0;
      m_nmi  = 0;
    end else if (m_run && t) begin
      if (m_cnt == 1) begin
        m_cnt = GRACE;
        if (m_hit) m_rst = 1;
        else begin m_hit = 1; m_nmi = 1; end
      end else m_cnt--;
    end
  endtask

  task automatic step(string tag, bit w, logic [7:0] a, logic [31:0] d, bit t);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; tick = t;
    #0.5;
    chk({tag, " rdata"}, rdata, (a == CA) ? m_ctrl : 32'd0);
    model_edge(w, a, d, t);
    @(posedge clk); #1;
    chk({tag, " nmi"}, 32'(nmi), 32'(m_nmi));
    chk({tag, " rst_req"}, 32'(rst_req), 32'(m_rst));
  endtask

  task automatic ticks(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, CA, 0, 1);
  endtask

  initial begin
    m_ctrl = 0; m_cnt = 0; m_run = 0; m_hit = 0; m_nmi = 0; m_rst = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset rdata", rdata, 32'd0);
    chk("R1 reset nmi", 32'(nmi), 0);
    chk("R1 reset rst_req", 32'(rst_req), 0);
    @(negedge clk); rst_n = 1;
    ticks("R1 stopped after reset", 300);

    step("R3 idle write any key", 1, CA, mk(7'h15, 1, 8'd3), 0);
    chk("R3 stored", rdata, mk(7'h15, 1, 8'd3));
    ticks("R7 count of 3", 2);
    chk("R7 nmi low before Nth tick", 32'(nmi), 0);
    ticks("R8 first expiry", 1);
    chk("R8 nmi set", 32'(nmi), 1);

    step("R2 wrong key", 1, CA, mk(7'h15, 0, 8'd9), 0);
    chk("R2 readback unchanged", rdata, mk(7'h15, 1, 8'd3));
    chk("R2 nmi still held", 32'(nmi), 1);

    ticks("R9 grace count", GRACE - 1);
    chk("R9 no reset yet", 32'(rst_req), 0);
    ticks("R9 second expiry", 1);
    chk("R9 reset pulse", 32'(rst_req), 1);
    ticks("R9 pulse one cycle", 0);
    step("R9 pulse ends", 0, CA, 0, 0);
    chk("R9 pulse ended", 32'(rst_req), 0);

    step("R10 keyed write stops", 1, CA, mk(7'h6A, 0, 8'd0), 0);
    chk("R10 nmi cleared", 32'(nmi), 0);
    ticks("R5 stopped by bit8=0", 400);
    chk("R5 no expiry when stopped", 32'(nmi), 0);

    step("R6 count zero", 1, CA, mk(7'h33, 1, 8'd0), 0);
    ticks("R6 255 ticks", 255);
    chk("R6 nmi low at 255", 32'(nmi), 0);
    ticks("R6 256th tick", 1);
    chk("R6 nmi at 256", 32'(nmi), 1);

    step("R4 foreign write", 1, 8'h44, mk(~7'h33, 0, 8'd1), 0);
    chk("R4 foreign read zero", rdata, 32'd0);
    step("R4 readback", 0, CA, 0, 0);
    chk("R4 ctrl unchanged", rdata, mk(7'h33, 1, 8'd0));
    chk("R4 nmi unchanged", 32'(nmi), 1);

    step("R11 write with tick", 1, CA, mk(~7'h33, 1, 8'd2), 1);
    chk("R10 nmi cleared by write", 32'(nmi), 0);
    ticks("R11 tick discarded", 1);
    chk("R11 not expired after one tick", 32'(nmi), 0);
    ticks("R11 second tick", 1);
    chk("R11 expired after two ticks", 32'(nmi), 1);

    void'($urandom(1234));
    for (int i = 0; i < 30000; i++) begin
      int r;
      bit w, t;
      logic [7:0] a, c;
      logic [6:0] k;
      r = $urandom_range(0, 199);
      w = (r < 3);
      t = ($urandom_range(0, 2) == 0);
      a = ($urandom_range(0, 9) == 0) ? 8'h48 : CA;
      k = ($urandom_range(0, 3) == 0) ? 7'($urandom) : good_key();
      c = ($urandom_range(0, 4) == 0) ? 8'($urandom) : 8'($urandom_range(0, 12));
      step("R7 R8 R9 random", w, a, mk(k, $urandom_range(0, 5) != 0, c), t);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule